// File: doc/BRIEF.md
# Split-Transfer I/O Bridge

A CPU with a three-line port selector performs its input and output instructions as a single machine cycle. During that cycle the byte moves straight between memory and a port. A shared backplane with separate memory-request and I/O-request strobes cannot serve two cards at once. This bridge sits between such a CPU and the backplane and splits each port instruction into two bus accesses. The first access reads the source, whether memory or port. The byte is held in an internal latch across one idle clock. The second access writes that byte to the destination.

Ordinary memory cycles, where the selector lines are all zero, pass through to the backplane unchanged. The port address is built from the selector value and a set of upper bits. Those upper bits come either from a small register that software loads beforehand, or from a fixed parameter. If the two accesses do not fit within the CPU's time window, the bridge raises a stall request so the CPU waits.

Top module: `io_split_bridge`

## Requirements
- R1: While idle with the selector equal to zero, the backplane address follows `cpu_addr`. `bus_rd_n` follows `cpu_mrd_n` and `bus_wr_n` follows `cpu_mwr_n`. `bus_mreq_n` is low while either CPU strobe is low. `bus_doe` is high with `cpu_dout` driven during a write, and `cpu_din` shows `bus_din`.
- R2: A split transfer starts only on a rising edge where `cpu_tpa` is high, the selector is nonzero and exactly one CPU strobe is low. A low `cpu_mrd_n` marks an output instruction and a low `cpu_mwr_n` marks an input instruction. If none of these apply, the bus stays quiet.
- R3: In an output instruction, the first phase holds `bus_mreq_n` and `bus_rd_n` low at the CPU address for ACC_CLKS clocks. The byte is captured on the last edge of that phase. In the second phase, `bus_iorq_n` and `bus_wr_n` are low at the port address for ACC_CLKS clocks, with the captured byte held on `bus_dout`.
- R4: In an input instruction, the first phase is a port read, with `bus_iorq_n` and `bus_rd_n` low at the port address. The second phase is a memory write of the captured byte to the CPU address. During the second phase `cpu_din` shows that byte.
- R5: Exactly one clock separates the two phases. In that clock all four strobes are high and the address still shows the first phase's address.
- R6: `bus_mreq_n` and `bus_iorq_n` are never low together, and neither are `bus_rd_n` and `bus_wr_n`.
- R7: The port address is `{upper, N}`. N is the 3-bit selector, in bits 2:0. `upper` is the port register when USE_PORT_REG=1, otherwise DEFAULT_HI. The address is zero-extended to the backplane width.
- R8: With USE_PORT_REG=1, an output instruction whose selector equals LOAD_N (default 3'b001) reads memory as usual. It loads bits 4:0 of the captured byte into the port register and keeps all strobes high in its second phase.
- R9: `cpu_wait` is high during a transfer in every clock whose count from the start of the first phase is at least WINDOW_CLKS.
- R10: While `rst_n` is low, all four strobes are high, and `bus_doe` and `cpu_wait` are low. Reset also clears the port register.
- R11: A `cpu_tpa` pulse during a transfer is ignored. The transfer runs to completion unchanged, and no new one starts from that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | AW | Full CPU memory address, valid when `cpu_tpa` is sampled |
| cpu_dout | input | DW | Byte driven by the CPU for memory writes |
| cpu_din | output | DW | Byte returned to the CPU |
| cpu_n | input | NW | Port selector lines; zero means an ordinary memory cycle |
| cpu_mrd_n | input | 1 | CPU memory-read strobe, active low |
| cpu_mwr_n | input | 1 | CPU memory-write strobe, active low |
| cpu_tpa | input | 1 | Marks the clock in which the full address is valid |
| cpu_wait | output | 1 | Stall request to the CPU |
| bus_addr | output | AW | Backplane address |
| bus_dout | output | DW | Byte driven onto the backplane |
| bus_doe | output | 1 | Backplane data drive enable (low means released) |
| bus_din | input | DW | Byte read from the backplane |
| bus_mreq_n | output | 1 | Memory request, active low |
| bus_iorq_n | output | 1 | I/O request, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
Counting from the edge that samples `cpu_tpa`, the first phase occupies clocks 0 to ACC_CLKS-1. The idle clock is clock ACC_CLKS, and the second phase ends at clock 2*ACC_CLKS, with the bridge idle one clock later. The bench drives inputs on falling edges and compares address, strobes, data and stall at the falling edge of each numbered clock against values it computes from the selector, the port-register contents and its own memory and port models. Pass-through results are combinational and are compared one time step after the inputs change. Destination contents, meaning the model memory cell or the last port write, are read after the transfer has finished.

// File: rtl/io_split_pkg.sv
package io_split_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_FIRST  = 2'd1,
      PH_GAP    = 2'd2,
      PH_SECOND = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      XF_NONE = 2'd0,
      XF_OUT  = 2'd1,
      XF_INP  = 2'd2,
      XF_LOAD = 2'd3
   } xfer_e;

endpackage

// File: rtl/io_split_seq.sv
module io_split_seq
   import io_split_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 8,
   parameter int NW           = 3,
   parameter int ACC_CLKS     = 2,
   parameter int WINDOW_CLKS  = 6,
   parameter int USE_PORT_REG = 1,
   parameter int LOAD_N       = 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_tpa,
   input  logic [NW-1:0] cpu_n,
   input  logic          cpu_mrd_n,
   input  logic          cpu_mwr_n,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] bus_din,
   output phase_e        phase_q,
   output xfer_e         xfer_q,
   output logic [AW-1:0] addr_q,
   output logic [NW-1:0] n_q,
   output logic [DW-1:0] latch_q,
   output logic          load_en,
   output logic          wait_o
);

   localparam int CW = (ACC_CLKS > 1) ? $clog2(ACC_CLKS) : 1;
   localparam int EW = $clog2(2 * ACC_CLKS + 2);
   localparam logic [CW-1:0] LAST = CW'(ACC_CLKS - 1);
   localparam logic [NW-1:0] LOAD_SEL = NW'(LOAD_N);

   logic [CW-1:0] cnt_q;
   logic [EW-1:0] elapsed_q;
   logic          start;
   xfer_e         kind;

   // a port instruction: nonzero selector, exactly one strobe active
   assign start = (phase_q == PH_IDLE) && cpu_tpa && (cpu_n != '0)
                  && (cpu_mrd_n ^ cpu_mwr_n);

   always_comb begin
      if (!cpu_mrd_n) begin
         kind = ((USE_PORT_REG != 0) && (cpu_n == LOAD_SEL)) ? XF_LOAD : XF_OUT;
      end else begin
         kind = XF_INP;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_IDLE;
         xfer_q    <= XF_NONE;
         cnt_q     <= '0;
         elapsed_q <= '0;
         addr_q    <= '0;
         n_q       <= '0;
         latch_q   <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q   <= PH_FIRST;
                  xfer_q    <= kind;
                  addr_q    <= cpu_addr;
                  n_q       <= cpu_n;
                  cnt_q     <= '0;
                  elapsed_q <= '0;
               end
            end
            PH_FIRST: begin
               elapsed_q <= elapsed_q + 1'b1;
               if (cnt_q == LAST) begin
                  latch_q <= bus_din;
                  cnt_q   <= '0;
                  phase_q <= PH_GAP;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_GAP: begin
               elapsed_q <= elapsed_q + 1'b1;
               phase_q   <= PH_SECOND;
            end
            PH_SECOND: begin
               elapsed_q <= elapsed_q + 1'b1;
               if (cnt_q == LAST) begin
                  cnt_q   <= '0;
                  phase_q <= PH_IDLE;
                  xfer_q  <= XF_NONE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign load_en = (phase_q == PH_FIRST) && (cnt_q == LAST) && (xfer_q == XF_LOAD);
   assign wait_o  = (phase_q != PH_IDLE) && (32'(elapsed_q) >= 32'(WINDOW_CLKS));

endmodule

// File: rtl/io_split_port.sv
module io_split_port #(
   parameter int NW           = 3,
   parameter int IO_AW        = 8,
   parameter int USE_PORT_REG = 1,
   parameter int DEFAULT_HI   = 0
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load_en,
   input  logic [IO_AW-NW-1:0] load_val,
   input  logic [NW-1:0]       n_q,
   output logic [IO_AW-1:0]    port_addr
);

   localparam int HW = IO_AW - NW;

   generate
      if (USE_PORT_REG != 0) begin : g_reg
         logic [HW-1:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q <= '0;
            end else if (load_en) begin
               hi_q <= load_val;
            end
         end
         assign port_addr = {hi_q, n_q};
      end else begin : g_fixed
         localparam logic [HW-1:0] HI = HW'(DEFAULT_HI);
         logic unused_fixed;
         assign unused_fixed = ^{clk, rst_n, load_en, load_val};
         assign port_addr    = {HI, n_q};
      end
   endgenerate

endmodule

// File: rtl/io_split_mux.sv
module io_split_mux
   import io_split_pkg::*;
#(
   parameter int AW    = 16,
   parameter int DW    = 8,
   parameter int NW    = 3,
   parameter int IO_AW = 8
)(
   input  logic             rst_n,
   input  phase_e           phase_q,
   input  xfer_e            xfer_q,
   input  logic [AW-1:0]    addr_q,
   input  logic [DW-1:0]    latch_q,
   input  logic [IO_AW-1:0] port_addr,
   input  logic             seq_wait,
   input  logic [AW-1:0]    cpu_addr,
   input  logic [DW-1:0]    cpu_dout,
   input  logic [NW-1:0]    cpu_n,
   input  logic             cpu_mrd_n,
   input  logic             cpu_mwr_n,
   input  logic [DW-1:0]    bus_din,
   output logic [DW-1:0]    cpu_din,
   output logic             cpu_wait,
   output logic [AW-1:0]    bus_addr,
   output logic [DW-1:0]    bus_dout,
   output logic             bus_doe,
   output logic             bus_mreq_n,
   output logic             bus_iorq_n,
   output logic             bus_rd_n,
   output logic             bus_wr_n
);

   logic [AW-1:0] io_addr;
   logic [AW-1:0] first_addr;

   assign io_addr    = AW'(port_addr);
   assign first_addr = (xfer_q == XF_INP) ? io_addr : addr_q;

   always_comb begin
      bus_addr   = cpu_addr;
      bus_dout   = cpu_dout;
      bus_doe    = 1'b0;
      bus_mreq_n = 1'b1;
      bus_iorq_n = 1'b1;
      bus_rd_n   = 1'b1;
      bus_wr_n   = 1'b1;
      if (rst_n) begin
         case (phase_q)
            PH_IDLE: begin
               if (cpu_n == '0) begin
                  bus_mreq_n = cpu_mrd_n & cpu_mwr_n;
                  bus_rd_n   = cpu_mrd_n;
                  bus_wr_n   = cpu_mwr_n;
                  bus_doe    = ~cpu_mwr_n;
               end
            end
            PH_FIRST: begin
               bus_addr = first_addr;
               bus_rd_n = 1'b0;
               if (xfer_q == XF_INP) begin
                  bus_iorq_n = 1'b0;
               end else begin
                  bus_mreq_n = 1'b0;
               end
            end
            PH_GAP: begin
               bus_addr = first_addr;
            end
            PH_SECOND: begin
               case (xfer_q)
                  XF_OUT: begin
                     bus_addr   = io_addr;
                     bus_iorq_n = 1'b0;
                     bus_wr_n   = 1'b0;
                     bus_doe    = 1'b1;
                     bus_dout   = latch_q;
                  end
                  XF_INP: begin
                     bus_addr   = addr_q;
                     bus_mreq_n = 1'b0;
                     bus_wr_n   = 1'b0;
                     bus_doe    = 1'b1;
                     bus_dout   = latch_q;
                  end
                  default: begin
                     bus_addr = addr_q;
                  end
               endcase
            end
            default: ;
         endcase
      end
   end

   assign cpu_din  = (phase_q != PH_IDLE) ? latch_q : bus_din;
   assign cpu_wait = rst_n & seq_wait;

endmodule

// File: rtl/io_split_bridge.sv
module io_split_bridge
   import io_split_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 8,
   parameter int NW           = 3,
   parameter int IO_AW        = 8,
   parameter int ACC_CLKS     = 2,
   parameter int WINDOW_CLKS  = 6,
   parameter int USE_PORT_REG = 1,
   parameter int LOAD_N       = 1,
   parameter int DEFAULT_HI   = 0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_dout,
   output logic [DW-1:0] cpu_din,
   input  logic [NW-1:0] cpu_n,
   input  logic          cpu_mrd_n,
   input  logic          cpu_mwr_n,
   input  logic          cpu_tpa,
   output logic          cpu_wait,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_dout,
   output logic          bus_doe,
   input  logic [DW-1:0] bus_din,
   output logic          bus_mreq_n,
   output logic          bus_iorq_n,
   output logic          bus_rd_n,
   output logic          bus_wr_n
);

   localparam int HW = IO_AW - NW;

   generate
      if (ACC_CLKS < 1) begin : g_bad_acc
         $error("ACC_CLKS must be at least 1");
      end
      if (WINDOW_CLKS < 1) begin : g_bad_window
         $error("WINDOW_CLKS must be at least 1");
      end
      if (IO_AW <= NW || IO_AW > AW) begin : g_bad_ioaw
         $error("IO_AW must exceed NW and fit in AW");
      end
      if (DW < HW) begin : g_bad_dw
         $error("DW must cover the port register width");
      end
      if (LOAD_N < 1 || LOAD_N >= (1 << NW)) begin : g_bad_load
         $error("LOAD_N must be a nonzero selector value");
      end
   endgenerate

   phase_e           phase_q;
   xfer_e            xfer_q;
   logic [AW-1:0]    addr_q;
   logic [NW-1:0]    n_q;
   logic [DW-1:0]    latch_q;
   logic             load_en;
   logic             seq_wait;
   logic [IO_AW-1:0] port_addr;

   io_split_seq #(
      .AW(AW), .DW(DW), .NW(NW), .ACC_CLKS(ACC_CLKS),
      .WINDOW_CLKS(WINDOW_CLKS), .USE_PORT_REG(USE_PORT_REG), .LOAD_N(LOAD_N)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cpu_tpa(cpu_tpa), .cpu_n(cpu_n),
      .cpu_mrd_n(cpu_mrd_n), .cpu_mwr_n(cpu_mwr_n), .cpu_addr(cpu_addr),
      .bus_din(bus_din), .phase_q(phase_q), .xfer_q(xfer_q), .addr_q(addr_q),
      .n_q(n_q), .latch_q(latch_q), .load_en(load_en), .wait_o(seq_wait)
   );

   io_split_port #(
      .NW(NW), .IO_AW(IO_AW), .USE_PORT_REG(USE_PORT_REG), .DEFAULT_HI(DEFAULT_HI)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(bus_din[HW-1:0]),
      .n_q(n_q), .port_addr(port_addr)
   );

   io_split_mux #(
      .AW(AW), .DW(DW), .NW(NW), .IO_AW(IO_AW)
   ) u_mux (
      .rst_n(rst_n), .phase_q(phase_q), .xfer_q(xfer_q), .addr_q(addr_q),
      .latch_q(latch_q), .port_addr(port_addr), .seq_wait(seq_wait),
      .cpu_addr(cpu_addr), .cpu_dout(cpu_dout), .cpu_n(cpu_n),
      .cpu_mrd_n(cpu_mrd_n), .cpu_mwr_n(cpu_mwr_n), .bus_din(bus_din),
      .cpu_din(cpu_din), .cpu_wait(cpu_wait), .bus_addr(bus_addr),
      .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_mreq_n(bus_mreq_n),
      .bus_iorq_n(bus_iorq_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
   );

endmodule

// File: rtl/io_split_checker.sv
module io_split_checker #(
   parameter int AW = 16,
   parameter int DW = 8,
   parameter int NW = 3
)(
   input logic          clk,
   input logic          rst_n,
   input logic [NW-1:0] cpu_n,
   input logic          cpu_wait,
   input logic [AW-1:0] bus_addr,
   input logic [DW-1:0] bus_dout,
   input logic          bus_doe,
   input logic          bus_mreq_n,
   input logic          bus_iorq_n,
   input logic          bus_rd_n,
   input logic          bus_wr_n
);

   AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_mreq_n || bus_iorq_n)); // R6

   AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_n || bus_wr_n)); // R6

   AST_IDLE_BEFORE_IO: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_iorq_n) |-> $past(bus_mreq_n)); // R5

   AST_READ_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n && $past(!bus_rd_n)) |-> $stable(bus_addr)); // R3

   AST_ADDR_HELD_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(bus_rd_n) && bus_mreq_n && bus_iorq_n) |-> $stable(bus_addr)); // R5

   AST_WRITE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_dout)); // R3

   AST_STALL_ONLY_FOR_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_wait |-> (cpu_n != '0)); // R9

   AST_QUIET_IN_RESET: assert property (@(posedge clk)
      !rst_n |-> (bus_mreq_n && bus_iorq_n && bus_rd_n && bus_wr_n
                  && !bus_doe && !cpu_wait)); // R10

endmodule

bind io_split_bridge io_split_checker #(.AW(AW), .DW(DW), .NW(NW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_n(cpu_n), .cpu_wait(cpu_wait),
   .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
   .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n),
   .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
);

// File: tb/tb_io_split_bridge.sv
module tb_io_split_bridge;

   localparam int CLK_PERIOD = 10;
   localparam int ACC = 3;
   localparam int WIN = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_dout = '0;
   logic [7:0]  cpu_din;
   logic [2:0]  cpu_n = '0;
   logic        cpu_mrd_n = 1'b1;
   logic        cpu_mwr_n = 1'b1;
   logic        cpu_tpa = 1'b0;
   logic        cpu_wait;
   logic [15:0] bus_addr;
   logic [7:0]  bus_dout;
   logic        bus_doe;
   logic [7:0]  bus_din;
   logic        bus_mreq_n, bus_iorq_n, bus_rd_n, bus_wr_n;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [7:0]  mem [0:255];
   int          io_wr_cnt;
   logic [15:0] io_wr_addr;
   logic [7:0]  io_wr_data;
   logic [4:0]  exp_hi = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   io_split_bridge #(
      .ACC_CLKS(ACC), .WINDOW_CLKS(WIN), .USE_PORT_REG(1), .LOAD_N(1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_dout(cpu_dout),
      .cpu_din(cpu_din), .cpu_n(cpu_n), .cpu_mrd_n(cpu_mrd_n),
      .cpu_mwr_n(cpu_mwr_n), .cpu_tpa(cpu_tpa), .cpu_wait(cpu_wait),
      .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .bus_din(bus_din), .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n),
      .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
   );

   function automatic logic [7:0] mem_init(input logic [7:0] a);
      return a * 8'd7 + 8'd3;
   endfunction

   // backplane models: memory card and port card
   always_comb begin
      bus_din = 8'h00;
      if (!bus_mreq_n && !bus_rd_n) bus_din = mem[bus_addr[7:0]];
      else if (!bus_iorq_n && !bus_rd_n) bus_din = bus_addr[7:0] ^ 8'h5A;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= mem_init(8'(i));
         io_wr_cnt  <= 0;
         io_wr_addr <= '0;
         io_wr_data <= '0;
      end else begin
         if (!bus_mreq_n && !bus_wr_n && bus_doe) mem[bus_addr[7:0]] <= bus_dout;
         if (!bus_iorq_n && !bus_wr_n) begin
            io_wr_cnt  <= io_wr_cnt + 1;
            io_wr_addr <= bus_addr;
            io_wr_data <= bus_dout;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [20:0] obs();
      return {bus_addr, bus_mreq_n, bus_iorq_n, bus_rd_n, bus_wr_n, bus_doe};
   endfunction

   // one port instruction, checked clock by clock
   task automatic do_io(input bit is_out, input logic [2:0] n, input logic [15:0] addr,
                        input bit poke, input string ptag);
      logic [7:0]  port8;
      logic [7:0]  exp_b;
      logic [15:0] first_a;
      bit          is_load;
      int          wr_base;
      port8   = {exp_hi, n};
      is_load = is_out && (n == 3'd1);
      exp_b   = is_out ? mem_init(addr[7:0]) : (port8 ^ 8'h5A);
      first_a = is_out ? addr : {8'h00, port8};
      @(negedge clk);
      cpu_addr  = addr;
      cpu_n     = n;
      cpu_mrd_n = !is_out;
      cpu_mwr_n = is_out;
      cpu_tpa   = 1'b1;
      wr_base   = io_wr_cnt;
      for (int e = 0; e <= 2 * ACC + 1; e++) begin
         @(negedge clk);
         cpu_tpa = poke && (e == 1);
         #1;
         if (e < ACC) begin
            if (is_out) chk("R3 first phase", 32'(obs()), 32'({first_a, 5'b01010}));
            else        chk("R4 first phase", 32'(obs()), 32'({first_a, 5'b10010}));
         end else if (e == ACC) begin
            chk("R5 idle clock", 32'(obs()), 32'({first_a, 5'b11110}));
         end else if (e <= 2 * ACC) begin
            if (is_load) begin
               chk("R8 silent second phase", 32'(obs()), 32'({addr, 5'b11110}));
            end else if (is_out) begin
               chk(ptag, 32'(obs()), 32'({8'h00, port8, 5'b10101}));
               chk("R3 write data", 32'(bus_dout), 32'(exp_b));
            end else begin
               chk("R4 second phase", 32'(obs()), 32'({addr, 5'b01101}));
               chk("R4 write data", 32'({bus_dout, cpu_din}), 32'({exp_b, exp_b}));
            end
         end else begin
            chk(poke ? "R11 finished, no restart" : "R2 back to idle",
                32'(obs()), 32'({addr, 5'b11110}));
         end
         chk("R9 stall", 32'(cpu_wait), 32'((e >= WIN && e <= 2 * ACC) ? 1 : 0));
      end
      @(negedge clk);
      cpu_n     = 3'd0;
      cpu_mrd_n = 1'b1;
      cpu_mwr_n = 1'b1;
      #1;
      if (is_load) begin
         chk("R8 no port write", 32'(io_wr_cnt - wr_base), 32'd0);
         exp_hi = exp_b[4:0];
      end else if (is_out) begin
         chk(ptag, 32'({io_wr_addr, io_wr_data}), 32'({8'h00, port8, exp_b}));
         chk("R3 write length", 32'(io_wr_cnt - wr_base), 32'(ACC));
      end else begin
         chk("R4 memory written", 32'(mem[addr[7:0]]), 32'(exp_b));
         chk("R4 no port write", 32'(io_wr_cnt - wr_base), 32'd0);
      end
   endtask

   task automatic pass_read(input logic [15:0] a, input logic [7:0] exp_b, input bit tpa);
      @(negedge clk);
      cpu_addr = a; cpu_n = 3'd0; cpu_mrd_n = 1'b0; cpu_tpa = tpa;
      #1;
      chk("R1 read strobes", 32'(obs()), 32'({a, 5'b01010}));
      chk("R1 read data", 32'(cpu_din), 32'(exp_b));
      @(negedge clk);
      cpu_tpa = 1'b0;
      #1;
      chk("R2 no start on zero selector", 32'(obs()), 32'({a, 5'b01010}));
      @(negedge clk);
      cpu_mrd_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cpu_n = 3'd0; cpu_mrd_n = 1'b0;
      #1;
      chk("R10 quiet in reset", 32'({obs(), cpu_wait}), 32'({16'h0000, 5'b11110, 1'b0}));
      @(negedge clk);
      cpu_mrd_n = 1'b1;
      #1;
      chk("R10 released in reset", 32'({bus_doe, cpu_wait}), 32'd0);
      rst_n = 1'b1;

      // R1: pass-through reads and a write
      pass_read(16'h1220, mem_init(8'h20), 1'b0);
      pass_read(16'hA531, mem_init(8'h31), 1'b1);
      @(negedge clk);
      cpu_addr = 16'h0040; cpu_dout = 8'hC3; cpu_mwr_n = 1'b0;
      #1;
      chk("R1 write strobes", 32'(obs()), 32'({16'h0040, 5'b01101}));
      chk("R1 write data", 32'(bus_dout), 32'h00C3);
      @(negedge clk);
      cpu_mwr_n = 1'b1;
      pass_read(16'h0040, 8'hC3, 1'b0);

      // R2: tpa with a nonzero selector but no strobe must not start
      @(negedge clk);
      cpu_addr = 16'h0050; cpu_n = 3'd5; cpu_tpa = 1'b1;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         cpu_tpa = 1'b0;
         #1;
         chk("R2 no strobe, no transfer", 32'({obs(), cpu_wait}), 32'({16'h0050, 5'b11110, 1'b0}));
      end
      @(negedge clk);
      cpu_n = 3'd0;

      // port register cleared by reset: upper port bits are zero
      do_io(1'b1, 3'd3, 16'h3013, 1'b0, "R10 cleared port register");
      for (int n = 2; n < 8; n++) do_io(1'b1, 3'(n), 16'h1010 + 16'(n), 1'b0, "R7 port address");
      for (int n = 1; n < 8; n++) do_io(1'b0, 3'(n), 16'h2080 + 16'(n), 1'b0, "R7 port address");

      // R8: load the port register, then sweep again with new upper bits
      do_io(1'b1, 3'd1, 16'h0033, 1'b0, "R8");
      for (int n = 2; n < 8; n++) do_io(1'b1, 3'(n), 16'h4020 + 16'(n), n == 4, "R7 loaded upper bits");
      for (int n = 1; n < 8; n++) do_io(1'b0, 3'(n), 16'h5090 + 16'(n), n == 6, "R7 loaded upper bits");
      do_io(1'b1, 3'd1, 16'h0061, 1'b0, "R8");
      do_io(1'b0, 3'd7, 16'h60A7, 1'b1, "R11");
      do_io(1'b1, 3'd5, 16'h7015, 1'b1, "R11 port write unchanged");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule